// File: doc/BRIEF.md
# Mailbox Channel State and Interrupt Controller

This block tracks a shared-memory mailbox between a host and an I/O coprocessor. There are seven send channels and seven receive channels. Each channel holds one message at a time: a 32-byte slot plus a two-bit state. Both sides drive state changes through their own write ports. The block accepts only the moves that the handshake allows for that side. A move that the handshake does not allow is refused, and a sticky per-channel error bit records it.

On the send side, the host posts a message and later retires the reply. On the receive side the roles are swapped: the coprocessor posts and retires, and the host acknowledges and completes. Two interrupt causes share one host line. The done cause fires when any send channel reaches COMPLETE. The arrival cause fires when any receive channel reaches NEW. Each cause is latched on the entry event and is cleared by a host acknowledge. Some host moves need the coprocessor's attention, and each of these produces a one-cycle doorbell pulse.

The block also contains the slot RAM and its address generator. It takes a direction, a channel and a byte index and returns the flat RAM address.

Top module: `mbox_top`

## Requirements
- R1: After reset every channel state is IDLE, all error bits, pending bits and interrupt status bits are 0, and hostIrq and doorbell are 0.
- R2: States are encoded IDLE=0, NEW=1, RCVD=2, COMPLETE=3, with channel i at bits [2i+1:2i] of its state vector. On a send channel the host may move IDLE→NEW and COMPLETE→IDLE, and the coprocessor may move NEW→RCVD and RCVD→COMPLETE. An accepted move is visible on the outputs one clock later.
- R3: On a receive channel the coprocessor may move IDLE→NEW and COMPLETE→IDLE, and the host may move NEW→RCVD and RCVD→COMPLETE.
- R4: Any other state write to channels 0 to 6 leaves the state unchanged and sets that channel's error bit in that direction one clock later. The error bit stays set until reset.
- R5: A state write naming channel 7 changes no state and no error bit.
- R6: intStatus[0] (done cause) sets one clock after a send channel enters COMPLETE. intStatus[1] (arrival cause) sets one clock after a receive channel enters NEW. hostIrq is the OR of the two bits.
- R7: A 1 on hostAck[k] clears intStatus[k] one clock later, unless a new entry event for that cause happens in the same cycle, in which case the bit stays set.
- R8: doorbell pulses high for one cycle, one clock after the host makes an accepted move to NEW on a send channel or to COMPLETE on a receive channel.
- R9: sendPend[i] is 1 exactly when send channel i is in COMPLETE. recvPend[i] is 1 exactly when receive channel i is in NEW.
- R10: memAddr is combinationally (memDir ? 224 : 0) + memChan×32 + memByte.
- R11: memWr stores memWData at memAddr for channels 0 to 6. memRData gives the byte held at the previous cycle's memAddr before any write in that cycle, or 0 if the previous cycle named channel 7.
- R12: If both sides write the same channel and direction in one cycle, the accepted move takes effect and the refused one sets the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostStWr | input | 1 | Host state write strobe |
| hostStDir | input | 1 | Host write direction (0 send, 1 receive) |
| hostStChan | input | 3 | Host write channel |
| hostStVal | input | 2 | Host write new state |
| copStWr | input | 1 | Coprocessor state write strobe |
| copStDir | input | 1 | Coprocessor write direction |
| copStChan | input | 3 | Coprocessor write channel |
| copStVal | input | 2 | Coprocessor write new state |
| hostAck | input | 2 | Per-cause interrupt acknowledge |
| memWr | input | 1 | Slot RAM write strobe |
| memDir | input | 1 | Slot direction |
| memChan | input | 3 | Slot channel |
| memByte | input | 5 | Byte in slot |
| memWData | input | 8 | Slot write data |
| sendStates | output | 14 | Send channel states, 2 bits each |
| recvStates | output | 14 | Receive channel states, 2 bits each |
| sendErr | output | 7 | Sticky send error bits |
| recvErr | output | 7 | Sticky receive error bits |
| sendPend | output | 7 | Send channels awaiting host |
| recvPend | output | 7 | Receive channels awaiting host |
| intStatus | output | 2 | Latched interrupt causes |
| hostIrq | output | 1 | Shared host interrupt |
| doorbell | output | 1 | Coprocessor doorbell pulse |
| memAddr | output | 9 | Flat slot RAM address |
| memRData | output | 8 | Slot RAM read data |

## Verification
A wrong channel state appears on sendStates or recvStates one clock after the faulty write. It also skews the pending vectors in that same cycle. Because the next move is then judged against the wrong state, it quickly produces a spurious error bit or a missing one. A cause bit that is latched or cleared wrongly shows on intStatus and hostIrq one clock after the entry or the acknowledge. The per-clock comparison with a behavioural model therefore exposes every state fault within one or two cycles of the stimulus that triggers it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_CH   = 7;
  localparam int MB_SLOT = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NEW  = 2'd1,
    ST_RCVD = 2'd2,
    ST_DONE = 2'd3
  } chState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             hostApply;
    logic             copApply;
    logic [MB_CH-1:0] sendErrSet;
    logic [MB_CH-1:0] recvErrSet;
    logic             doneEntry;
    logic             newEntry;
    logic             ring;
  } mbStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NCH = MB_CH,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic               hostStWr,
  input  logic               hostStDir,
  input  logic [CW-1:0]      hostStChan,
  input  logic [1:0]         hostStVal,
  input  logic               copStWr,
  input  logic               copStDir,
  input  logic [CW-1:0]      copStChan,
  input  logic [1:0]         copStVal,
  input  logic [2*NCH-1:0]   sendStates,
  input  logic [2*NCH-1:0]   recvStates,
  output mbStrobe_t          stb
);

  function automatic logic [1:0] pickState(logic [2*NCH-1:0] vec, logic [CW-1:0] ch);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 0; i < NCH; i++)
      if (ch == CW'(i)) r = vec[2*i +: 2];
    return r;
  endfunction

  // owner posts (IDLE->NEW) and retires (DONE->IDLE); peer accepts and completes
  function automatic logic moveOk(logic owner, logic [1:0] cur, logic [1:0] nxt);
    if (owner)
      return (cur == ST_IDLE && nxt == ST_NEW) || (cur == ST_DONE && nxt == ST_IDLE);
    else
      return (cur == ST_NEW && nxt == ST_RCVD) || (cur == ST_RCVD && nxt == ST_DONE);
  endfunction

  logic       hostValid, copValid, hostLegal, copLegal;
  logic [1:0] hostCur, copCur;

  always_comb begin
    hostValid = hostStWr && (hostStChan < CW'(NCH));
    copValid  = copStWr && (copStChan < CW'(NCH));
    hostCur   = hostStDir ? pickState(recvStates, hostStChan) : pickState(sendStates, hostStChan);
    copCur    = copStDir ? pickState(recvStates, copStChan) : pickState(sendStates, copStChan);
    hostLegal = hostValid && moveOk(!hostStDir, hostCur, hostStVal);
    copLegal  = copValid && moveOk(copStDir, copCur, copStVal);

    stb = '0;
    stb.hostApply = hostLegal;
    stb.copApply  = copLegal;
    for (int i = 0; i < NCH; i++) begin
      if (hostValid && !hostLegal && hostStChan == CW'(i)) begin
        if (hostStDir) stb.recvErrSet[i] = 1'b1;
        else           stb.sendErrSet[i] = 1'b1;
      end
      if (copValid && !copLegal && copStChan == CW'(i)) begin
        if (copStDir) stb.recvErrSet[i] = 1'b1;
        else          stb.sendErrSet[i] = 1'b1;
      end
    end
    stb.doneEntry = copLegal && !copStDir && copStVal == ST_DONE;
    stb.newEntry  = copLegal && copStDir && copStVal == ST_NEW;
    stb.ring      = hostLegal && (hostStDir ? hostStVal == ST_DONE : hostStVal == ST_NEW);
  end

endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int NCH  = MB_CH,
  parameter int SLOT = MB_SLOT,
  localparam int CW    = $clog2(NCH + 1),
  localparam int BW    = $clog2(SLOT),
  localparam int DEPTH = 2 * NCH * SLOT,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbStrobe_t        stb,
  input  logic             hostStDir,
  input  logic [CW-1:0]    hostStChan,
  input  logic [1:0]       hostStVal,
  input  logic             copStDir,
  input  logic [CW-1:0]    copStChan,
  input  logic [1:0]       copStVal,
  input  logic [1:0]       hostAck,
  input  logic             memWr,
  input  logic             memDir,
  input  logic [CW-1:0]    memChan,
  input  logic [BW-1:0]    memByte,
  input  logic [7:0]       memWData,
  output logic [2*NCH-1:0] sendStates,
  output logic [2*NCH-1:0] recvStates,
  output logic [NCH-1:0]   sendErr,
  output logic [NCH-1:0]   recvErr,
  output logic [NCH-1:0]   sendPend,
  output logic [NCH-1:0]   recvPend,
  output logic [1:0]       intStatus,
  output logic             doorbell,
  output logic [AW-1:0]    memAddr,
  output logic [7:0]       memRData
);

  localparam logic [AW-1:0] RECV_BASE = AW'(NCH * SLOT);

  logic [7:0] slotRam [DEPTH];
  logic       memOk;

  // channel state and sticky errors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendStates <= '0;
      recvStates <= '0;
      sendErr    <= '0;
      recvErr    <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (stb.hostApply && !hostStDir && hostStChan == CW'(i))
          sendStates[2*i +: 2] <= hostStVal;
        else if (stb.copApply && !copStDir && copStChan == CW'(i))
          sendStates[2*i +: 2] <= copStVal;
        if (stb.hostApply && hostStDir && hostStChan == CW'(i))
          recvStates[2*i +: 2] <= hostStVal;
        else if (stb.copApply && copStDir && copStChan == CW'(i))
          recvStates[2*i +: 2] <= copStVal;
      end
      sendErr <= sendErr | stb.sendErrSet;
      recvErr <= recvErr | stb.recvErrSet;
    end
  end

  // interrupt causes latch on entry, entry wins over acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStatus <= '0;
      doorbell  <= 1'b0;
    end else begin
      if (stb.doneEntry)       intStatus[0] <= 1'b1;
      else if (hostAck[0])     intStatus[0] <= 1'b0;
      if (stb.newEntry)        intStatus[1] <= 1'b1;
      else if (hostAck[1])     intStatus[1] <= 1'b0;
      doorbell <= stb.ring;
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sendPend[i] = sendStates[2*i +: 2] == ST_DONE;
      recvPend[i] = recvStates[2*i +: 2] == ST_NEW;
    end
  end

  // slot address and RAM
  assign memOk   = memChan < CW'(NCH);
  assign memAddr = (memDir ? RECV_BASE : AW'(0)) + AW'({memChan, {BW{1'b0}}}) + AW'(memByte);

  always_ff @(posedge clk) begin
    if (memWr && memOk) slotRam[memAddr] <= memWData;
    memRData <= memOk ? slotRam[memAddr] : 8'd0;
  end

endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int NCH  = MB_CH,
  parameter int SLOT = MB_SLOT,
  localparam int CW = $clog2(NCH + 1),
  localparam int BW = $clog2(SLOT),
  localparam int AW = $clog2(2 * NCH * SLOT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostStWr,
  input  logic             hostStDir,
  input  logic [CW-1:0]    hostStChan,
  input  logic [1:0]       hostStVal,
  input  logic             copStWr,
  input  logic             copStDir,
  input  logic [CW-1:0]    copStChan,
  input  logic [1:0]       copStVal,
  input  logic [1:0]       hostAck,
  input  logic             memWr,
  input  logic             memDir,
  input  logic [CW-1:0]    memChan,
  input  logic [BW-1:0]    memByte,
  input  logic [7:0]       memWData,
  output logic [2*NCH-1:0] sendStates,
  output logic [2*NCH-1:0] recvStates,
  output logic [NCH-1:0]   sendErr,
  output logic [NCH-1:0]   recvErr,
  output logic [NCH-1:0]   sendPend,
  output logic [NCH-1:0]   recvPend,
  output logic [1:0]       intStatus,
  output logic             hostIrq,
  output logic             doorbell,
  output logic [AW-1:0]    memAddr,
  output logic [7:0]       memRData
);

  mbStrobe_t stb;

  mbox_ctrl #(.NCH(NCH)) i_ctrl (
    .hostStWr(hostStWr), .hostStDir(hostStDir), .hostStChan(hostStChan), .hostStVal(hostStVal),
    .copStWr(copStWr), .copStDir(copStDir), .copStChan(copStChan), .copStVal(copStVal),
    .sendStates(sendStates), .recvStates(recvStates), .stb(stb)
  );

  mbox_dp #(.NCH(NCH), .SLOT(SLOT)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostStDir(hostStDir), .hostStChan(hostStChan), .hostStVal(hostStVal),
    .copStDir(copStDir), .copStChan(copStChan), .copStVal(copStVal),
    .hostAck(hostAck), .memWr(memWr), .memDir(memDir), .memChan(memChan),
    .memByte(memByte), .memWData(memWData),
    .sendStates(sendStates), .recvStates(recvStates), .sendErr(sendErr), .recvErr(recvErr),
    .sendPend(sendPend), .recvPend(recvPend), .intStatus(intStatus), .doorbell(doorbell),
    .memAddr(memAddr), .memRData(memRData)
  );

  assign hostIrq = |intStatus;

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int NCH = 7,
  parameter int CW  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostStWr,
  input logic             hostStDir,
  input logic [1:0]       hostStVal,
  input logic             copStWr,
  input logic             copStDir,
  input logic [CW-1:0]    copStChan,
  input logic [1:0]       copStVal,
  input logic [1:0]       hostAck,
  input logic [2*NCH-1:0] sendStates,
  input logic [2*NCH-1:0] recvStates,
  input logic [NCH-1:0]   sendErr,
  input logic [NCH-1:0]   recvErr,
  input logic [1:0]       intStatus,
  input logic             doorbell
);

  // R2
  no_silent_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostStWr && !copStWr) |=> ($stable(sendStates) && $stable(recvStates)));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((sendErr & $past(sendErr)) == $past(sendErr)) &&
              ((recvErr & $past(recvErr)) == $past(recvErr))));

  // R5
  bad_chan_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (copStWr && copStChan == CW'(NCH) && !hostStWr) |=>
      ($stable(sendStates) && $stable(recvStates) && $stable(sendErr) && $stable(recvErr)));

  // R6
  arrival_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[1]) |-> $past(copStWr && copStDir && copStVal == 2'd1));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck[0] && !(copStWr && !copStDir && copStVal == 2'd3)) |=> !intStatus[0]);

  // R8
  doorbell_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |-> $past(hostStWr && ((!hostStDir && hostStVal == 2'd1) ||
                                    (hostStDir && hostStVal == 2'd3))));

endmodule

bind mbox_top mbox_chk #(.NCH(NCH), .CW(CW)) i_chk (
  .clk(clk), .rstN(rstN), .hostStWr(hostStWr), .hostStDir(hostStDir), .hostStVal(hostStVal),
  .copStWr(copStWr), .copStDir(copStDir), .copStChan(copStChan), .copStVal(copStVal),
  .hostAck(hostAck), .sendStates(sendStates), .recvStates(recvStates),
  .sendErr(sendErr), .recvErr(recvErr), .intStatus(intStatus), .doorbell(doorbell)
);

// File: tb/test_mbox_top.sv
module test_mbox_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       hostStWr = 0, hostStDir = 0, copStWr = 0, copStDir = 0;
  logic [2:0] hostStChan = 0, copStChan = 0, memChan = 0;
  logic [1:0] hostStVal = 0, copStVal = 0, hostAck = 0;
  logic       memWr = 0, memDir = 0;
  logic [4:0] memByte = 0;
  logic [7:0] memWData = 0;
  logic [13:0] sendStates, recvStates;
  logic [6:0]  sendErr, recvErr, sendPend, recvPend;
  logic [1:0]  intStatus;
  logic        hostIrq, doorbell;
  logic [8:0]  memAddr;
  logic [7:0]  memRData;

  mbox_top i_mbox_top (.*);

  // behavioural reference
  int  ss[7], rs[7];
  bit  se[7], re[7];
  bit  i0, i1, db;
  byte mm[448];
  bit  mv[448];
  bit  rdKnown;
  int  rdExp;
  int  nChk = 0, nFail = 0;
  bit  finished = 0;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit okMove(bit owner, int cur, int v);
    if (owner) return (cur == 0 && v == 1) || (cur == 3 && v == 0);
    return (cur == 1 && v == 2) || (cur == 2 && v == 3);
  endfunction

  function automatic int packSt(bit rx);
    int r = 0;
    for (int i = 0; i < 7; i++) r |= (rx ? rs[i] : ss[i]) << (2 * i);
    return r;
  endfunction

  function automatic int packBits(int which);
    int r = 0;
    for (int i = 0; i < 7; i++) begin
      bit b;
      case (which)
        0: b = se[i];
        1: b = re[i];
        2: b = (ss[i] == 3);
        default: b = (rs[i] == 1);
      endcase
      r |= int'(b) << i;
    end
    return r;
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < 7; i++) begin ss[i] = 0; rs[i] = 0; se[i] = 0; re[i] = 0; end
    i0 = 0; i1 = 0; db = 0; rdKnown = 0;
  endfunction

  task automatic compareAll();
    chk("R2 send states", int'(sendStates), packSt(0));
    chk("R3 recv states", int'(recvStates), packSt(1));
    chk("R4 send err", int'(sendErr), packBits(0));
    chk("R4 recv err", int'(recvErr), packBits(1));
    chk("R9 send pend", int'(sendPend), packBits(2));
    chk("R9 recv pend", int'(recvPend), packBits(3));
    chk("R7 intStatus", int'(intStatus), {i1, i0});
    chk("R6 hostIrq", int'(hostIrq), int'(i0 | i1));
    chk("R8 doorbell", int'(doorbell), int'(db));
    if (rdKnown) chk("R11 memRData", int'(memRData), rdExp);
  endtask

  // model the edge that follows the currently driven inputs
  function automatic void modelStep();
    bit hv, cv, hL, cL, done, nw, mOk;
    int hc, cc, a;
    hv = hostStWr && hostStChan < 7;
    cv = copStWr && copStChan < 7;
    hc = hv ? (hostStDir ? rs[hostStChan] : ss[hostStChan]) : 0;
    cc = cv ? (copStDir ? rs[copStChan] : ss[copStChan]) : 0;
    hL = hv && okMove(!hostStDir, hc, hostStVal);
    cL = cv && okMove(copStDir, cc, copStVal);
    if (hv && !hL) begin if (hostStDir) re[hostStChan] = 1; else se[hostStChan] = 1; end
    if (cv && !cL) begin if (copStDir) re[copStChan] = 1; else se[copStChan] = 1; end
    if (hL) begin if (hostStDir) rs[hostStChan] = hostStVal; else ss[hostStChan] = hostStVal; end
    if (cL) begin if (copStDir) rs[copStChan] = copStVal; else ss[copStChan] = copStVal; end
    db   = hL && (hostStDir ? hostStVal == 3 : hostStVal == 1);
    done = cL && !copStDir && copStVal == 3;
    nw   = cL && copStDir && copStVal == 1;
    i0 = done ? 1'b1 : (hostAck[0] ? 1'b0 : i0);
    i1 = nw ? 1'b1 : (hostAck[1] ? 1'b0 : i1);
    mOk = memChan < 7;
    a = (memDir ? 224 : 0) + memChan * 32 + memByte;
    if (mOk) begin rdKnown = mv[a]; rdExp = int'(mm[a]) & 8'hff; end
    else begin rdKnown = 1; rdExp = 0; end
    if (memWr && mOk) begin mm[a] = memWData; mv[a] = 1; end
  endfunction

  // at a negedge: compare, then the caller has set inputs; check address, model next edge
  task automatic finishCycle();
    #1;
    chk("R10 memAddr", int'(memAddr), (memDir ? 224 : 0) + memChan * 32 + memByte);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleInputs();
    hostStWr = 0; copStWr = 0; hostAck = 0; memWr = 0;
  endtask

  task automatic randomInputs(bit legalOnly);
    idleInputs();
    memWr = ($urandom % 3) == 0;
    memDir = $urandom; memChan = ($urandom % 16 == 0) ? 3'd7 : 3'($urandom % 7);
    memByte = $urandom; memWData = $urandom;
    hostAck = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
    if (legalOnly) begin
      bit d = $urandom; int ch = $urandom % 7; int cur;
      bit owner;
      cur = d ? rs[ch] : ss[ch];
      owner = (cur == 0 || cur == 3);
      // owner of send is host, owner of receive is coprocessor
      if (owner ^ d) begin
        hostStWr = 1; hostStDir = d; hostStChan = 3'(ch); hostStVal = 2'((cur + 1) % 4);
      end else begin
        copStWr = 1; copStDir = d; copStChan = 3'(ch); copStVal = 2'((cur + 1) % 4);
      end
    end else begin
      hostStWr = ($urandom % 2) == 0; hostStDir = $urandom;
      hostStChan = ($urandom % 10 == 0) ? 3'd7 : 3'($urandom % 7); hostStVal = $urandom;
      copStWr = ($urandom % 2) == 0; copStDir = $urandom;
      copStChan = ($urandom % 10 == 0) ? 3'd7 : 3'($urandom % 7); copStVal = $urandom;
    end
  endtask

  task automatic doReset();
    idleInputs();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelReset();
    // R1 reset state
    chk("R1 reset send", int'(sendStates), 0);
    chk("R1 reset recv", int'(recvStates), 0);
    chk("R1 reset err", int'({sendErr, recvErr}), 0);
    chk("R1 reset pend", int'({sendPend, recvPend}), 0);
    chk("R1 reset irq", int'({intStatus, hostIrq, doorbell}), 0);
  endtask

  initial begin
    logic [13:0] snapS, snapR;
    logic [6:0]  snapE;
    doReset();
    // phase with arbitrary writes
    for (int n = 0; n < 1500; n++) begin randomInputs(0); finishCycle(); end
    doReset();
    // phase with handshake-conforming writes only
    for (int n = 0; n < 1500; n++) begin randomInputs(1); finishCycle(); end
    doReset();

    // R5: channel 7 writes leave everything alone
    snapS = sendStates; snapR = recvStates; snapE = sendErr;
    idleInputs(); hostStWr = 1; hostStDir = 0; hostStChan = 3'd7; hostStVal = 2'd1;
    copStWr = 1; copStDir = 1; copStChan = 3'd7; copStVal = 2'd1;
    finishCycle();
    chk("R5 states after ch7", int'({sendStates, recvStates}), int'({snapS, snapR}));
    chk("R5 errors after ch7", int'({sendErr, recvErr}), int'({snapE, 7'd0}));

    // R12: send ch0 to NEW, then both sides write ch0 together
    idleInputs(); hostStWr = 1; hostStDir = 0; hostStChan = 3'd0; hostStVal = 2'd1;
    finishCycle();
    chk("R8 doorbell after post", int'(doorbell), 1);
    idleInputs(); hostStWr = 1; hostStDir = 0; hostStChan = 3'd0; hostStVal = 2'd0;
    copStWr = 1; copStDir = 0; copStChan = 3'd0; copStVal = 2'd2;
    finishCycle();
    chk("R12 accepted move", int'(sendStates[1:0]), 2);
    chk("R12 refused move err", int'(sendErr[0]), 1);

    // R7: entry to COMPLETE while acknowledging keeps the cause set
    idleInputs(); copStWr = 1; copStDir = 0; copStChan = 3'd0; copStVal = 2'd3; hostAck = 2'b01;
    finishCycle();
    chk("R7 entry beats ack", int'(intStatus[0]), 1);
    idleInputs(); hostAck = 2'b01;
    finishCycle();
    chk("R7 ack clears", int'(intStatus[0]), 0);

    // R10: last byte of last receive slot
    idleInputs(); memDir = 1; memChan = 3'd6; memByte = 5'd31;
    #1 chk("R10 top address", int'(memAddr), 447);
    finishCycle();

    idleInputs();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule